// File: doc/BRIEF.md
# Comparator Change-Detect Interrupt Logic

This block watches the digital outputs of a set of analog comparators and raises a per-channel interrupt flag when an output moves away from the level that software last saw. Each channel keeps two state bits. A reference bit is loaded when software accesses the control register. A sampling bit follows the comparator once per instruction cycle, on a sample strobe. When the two differ the channel is in mismatch, and the mismatch pins the channel's flag high.

The comparator levels arrive from outside the clock domain. A short synchronizer chain brings them into the clock domain before the sampling bit sees them. Software reads the control register to learn the present levels, and that read also ends the mismatch. It then writes 0 to the flag to acknowledge. A write of 1 to the flag raises an interrupt with no comparator change behind it. The interrupt request is a registered AND of each flag with its channel enable, a peripheral enable and a global enable.

Top module: `cmp_chg_irq`

## Requirements
- R1: On every cycle in which `ctl_rd` is high, each channel's reference bit loads a level, and `ctl_level[i]` presents the reference bit of channel i. With neither `ctl_rd` nor `ctl_wr` high, `ctl_level` holds its value.
- R2: A cycle with `ctl_wr` high reloads the reference bits exactly as a read does, so it also ends a mismatch.
- R3: `cmp_async` passes through two synchronizer flops. The sampling bit loads only on cycles with `smp_stb` high. With the strobe held high, a level change applied before clock edge 1 first appears on `flag` after edge 4.
- R4: While a channel's reference and sampling bits differ, its flag is 1 after the next edge. This holds even if a flag write of 0 happens in the same cycle.
- R5: When the comparator level returns to the reference level, the mismatch ends without any access, and the flag stays 1.
- R6: A flag write (`flg_wr` high, `flg_wdata[i]` = 0 for channel i) clears the flag on the next edge only when that channel has no mismatch. Without a write and without a mismatch, the flag holds.
- R7: A flag write with `flg_wdata[i]` = 1 sets flag i on the next edge.
- R8: `irq` is a registered output. It is 1 one edge after any channel has `flag[i]` and `ch_en[i]` both high while `periph_en` and `global_en` are also high. Otherwise it is 0. Flags set regardless of the enables.
- R9: When a control access and `smp_stb` fall in the same cycle, the reference bit loads the newly sampled level, so no mismatch follows.
- R10: Synchronous `rst` clears the synchronizers, the reference bits, the sampling bits, the flags and `irq` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_async | input | NCH | Comparator outputs, asynchronous, bit i = channel i |
| smp_stb | input | 1 | Once-per-instruction-cycle sample strobe |
| ctl_rd | input | 1 | Control register read strobe |
| ctl_wr | input | 1 | Control register write strobe |
| flg_wr | input | 1 | Flag register write strobe |
| flg_wdata | input | NCH | Flag write data, bit i = channel i |
| ch_en | input | NCH | Per-channel interrupt enable |
| periph_en | input | 1 | Peripheral interrupt enable |
| global_en | input | 1 | Global interrupt enable |
| ctl_level | output | NCH | Referenced comparator levels, as returned by a control read |
| flag | output | NCH | Per-channel interrupt flags |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench aims at a flag clear that arrives while the mismatch persists. A design that lets the clear win would drop a pending change. It also checks that a control write reloads the reference like a read; without that, a write would leave the flag stuck. A sample strobe that coincides with a read must not produce a phantom mismatch, and a design that loads the old sample there would raise a false flag. The count of edges from an input change to the flag pins down the synchronizer depth. Removing the strobe gating shows up as a flag raised while the strobe is low.

// File: rtl/cmp_chg_pkg.sv
package cmp_chg_pkg;
  parameter int unsigned DEF_NCH    = 2;
  parameter int unsigned DEF_STAGES = 2;

  typedef struct packed {
    logic ref_lvl;
    logic flag;
    logic mis;
  } chan_st_t;
endpackage

// File: rtl/cmp_chg_sync.sv
module cmp_chg_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cmp_chg_chan.sv
module cmp_chg_chan
  import cmp_chg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     lvl,
  input  logic     smp_stb,
  input  logic     ctl_acc,
  input  logic     flg_wr,
  input  logic     flg_wd,
  output chan_st_t st
);
  logic samp_q, ref_q, flag_q, flag_d, mis;

  assign mis = ref_q ^ samp_q;

  always_comb begin
    flag_d = flag_q;
    if (flg_wr) flag_d = flg_wd;
    if (mis)    flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q <= 1'b0;
      ref_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (smp_stb) samp_q <= lvl;
      if (ctl_acc) ref_q  <= smp_stb ? lvl : samp_q;
      flag_q <= flag_d;
    end
  end

  assign st = '{ref_lvl: ref_q, flag: flag_q, mis: mis};
endmodule

// File: rtl/cmp_chg_req.sv
module cmp_chg_req #(
  parameter int unsigned NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] flag,
  input  logic [NCH-1:0] ch_en,
  input  logic           periph_en,
  input  logic           global_en,
  output logic           irq
);
  logic any_on;
  assign any_on = |(flag & ch_en);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= any_on & periph_en & global_en;
  end
endmodule

// File: rtl/cmp_chg_irq.sv
module cmp_chg_irq
  import cmp_chg_pkg::*;
#(
  parameter int unsigned NCH    = DEF_NCH,
  parameter int unsigned STAGES = DEF_STAGES
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] cmp_async,
  input  logic           smp_stb,
  input  logic           ctl_rd,
  input  logic           ctl_wr,
  input  logic           flg_wr,
  input  logic [NCH-1:0] flg_wdata,
  input  logic [NCH-1:0] ch_en,
  input  logic           periph_en,
  input  logic           global_en,
  output logic [NCH-1:0] ctl_level,
  output logic [NCH-1:0] flag,
  output logic           irq
);
  logic [NCH-1:0] lvl_sync;
  logic [NCH-1:0] mis_vec;
  logic           ctl_acc;
  chan_st_t       ch_st [NCH];

  assign ctl_acc = ctl_rd | ctl_wr;

  cmp_chg_sync #(.W(NCH), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(cmp_async), .q(lvl_sync)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cmp_chg_chan u_ch (
      .clk(clk), .rst(rst), .lvl(lvl_sync[i]), .smp_stb(smp_stb),
      .ctl_acc(ctl_acc), .flg_wr(flg_wr), .flg_wd(flg_wdata[i]),
      .st(ch_st[i])
    );
    assign ctl_level[i] = ch_st[i].ref_lvl;
    assign flag[i]      = ch_st[i].flag;
    assign mis_vec[i]   = ch_st[i].mis;
  end

  cmp_chg_req #(.NCH(NCH)) u_req (
    .clk(clk), .rst(rst), .flag(flag), .ch_en(ch_en),
    .periph_en(periph_en), .global_en(global_en), .irq(irq)
  );
endmodule

// File: rtl/cmp_chg_irq_chk.sv
module cmp_chg_irq_chk #(
  parameter int unsigned NCH = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           ctl_rd,
  input logic           ctl_wr,
  input logic           flg_wr,
  input logic [NCH-1:0] flg_wdata,
  input logic [NCH-1:0] ch_en,
  input logic           periph_en,
  input logic           global_en,
  input logic [NCH-1:0] ctl_level,
  input logic [NCH-1:0] flag,
  input logic [NCH-1:0] mis,
  input logic           irq
);
  // R10: reset leaves everything cleared
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (flag == '0 && ctl_level == '0 && !irq));

  // R1: without a control access the referenced levels do not move
  a_r1_level_hold: assert property (@(posedge clk) disable iff (rst)
    !(ctl_rd || ctl_wr) |=> $stable(ctl_level));

  // R8: the global enable masks the request
  a_r8_global_mask: assert property (@(posedge clk) disable iff (rst)
    !global_en |=> !irq);

  // R8: a fully enabled flag raises the request
  a_r8_enabled_req: assert property (@(posedge clk) disable iff (rst)
    (|(flag & ch_en) && periph_en && global_en) |=> irq);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // R4: mismatch pins the flag
    a_r4_mis_sets_flag: assert property (@(posedge clk) disable iff (rst)
      mis[i] |=> flag[i]);

    // R6: no write leaves a set flag set
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
      (flag[i] && !flg_wr) |=> flag[i]);

    // R7: writing 1 sets the flag
    a_r7_soft_set: assert property (@(posedge clk) disable iff (rst)
      (flg_wr && flg_wdata[i]) |=> flag[i]);
  end
endmodule

bind cmp_chg_irq cmp_chg_irq_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .ctl_rd(ctl_rd), .ctl_wr(ctl_wr),
  .flg_wr(flg_wr), .flg_wdata(flg_wdata), .ch_en(ch_en),
  .periph_en(periph_en), .global_en(global_en),
  .ctl_level(ctl_level), .flag(flag), .mis(mis_vec), .irq(irq)
);

// File: tb/cmp_chg_irq_test.sv
module cmp_chg_irq_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NCH  = 2;
  localparam int HOLD = 6;

  logic           clk = 1'b0;
  logic           rst;
  logic [NCH-1:0] cmp_async;
  logic           smp_stb, ctl_rd, ctl_wr, flg_wr;
  logic [NCH-1:0] flg_wdata, ch_en;
  logic           periph_en, global_en;
  logic [NCH-1:0] ctl_level, flag;
  logic           irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  cmp_chg_irq #(.NCH(NCH)) uut (
    .clk(clk), .rst(rst), .cmp_async(cmp_async), .smp_stb(smp_stb),
    .ctl_rd(ctl_rd), .ctl_wr(ctl_wr), .flg_wr(flg_wr), .flg_wdata(flg_wdata),
    .ch_en(ch_en), .periph_en(periph_en), .global_en(global_en),
    .ctl_level(ctl_level), .flag(flag), .irq(irq)
  );

  typedef struct packed {
    logic [1:0] cmp;
    logic       stb, rd, wr, fwr;
    logic [1:0] fdat, chen;
    logic       pen, gen;
    logic [1:0] xflag, xlvl;
    logic       xirq;
    logic [3:0] req;
  } vec_t;

  // each row is held HOLD cycles, then flag, ctl_level and irq are checked
  localparam vec_t VECS [15] = '{
    '{2'b00,1,0,0,0,2'b00,2'b11,1,1, 2'b00,2'b00,0, 4'd10}, // R10 quiet start
    '{2'b01,1,0,0,0,2'b00,2'b11,1,1, 2'b01,2'b00,1, 4'd4},  // R4 change sets flag
    '{2'b00,1,0,0,0,2'b00,2'b11,1,1, 2'b01,2'b00,1, 4'd5},  // R5 return, flag stays
    '{2'b00,1,0,0,1,2'b00,2'b11,1,1, 2'b00,2'b00,0, 4'd6},  // R6 clear works
    '{2'b10,1,0,0,0,2'b00,2'b11,1,1, 2'b10,2'b00,1, 4'd4},  // R4 channel 1
    '{2'b10,1,0,0,1,2'b00,2'b11,1,1, 2'b10,2'b00,1, 4'd6},  // R6 clear blocked
    '{2'b10,1,1,0,0,2'b00,2'b11,1,1, 2'b10,2'b10,1, 4'd1},  // R1 read takes level
    '{2'b10,1,0,0,1,2'b00,2'b11,1,1, 2'b00,2'b10,0, 4'd6},  // R6 clear after read
    '{2'b11,1,0,0,0,2'b00,2'b11,1,0, 2'b01,2'b10,0, 4'd8},  // R8 flag w/o global
    '{2'b11,1,0,1,1,2'b00,2'b11,1,0, 2'b00,2'b11,0, 4'd2},  // R2 write reloads
    '{2'b11,1,0,0,1,2'b10,2'b11,0,1, 2'b10,2'b11,0, 4'd7},  // R7 soft set, no periph
    '{2'b11,1,0,0,0,2'b00,2'b01,1,1, 2'b10,2'b11,0, 4'd8},  // R8 channel masked
    '{2'b11,1,0,0,0,2'b00,2'b10,1,1, 2'b10,2'b11,1, 4'd8},  // R8 all enabled
    '{2'b00,0,0,0,0,2'b00,2'b10,1,1, 2'b10,2'b11,1, 4'd3},  // R3 no strobe
    '{2'b00,1,0,0,0,2'b00,2'b10,1,1, 2'b11,2'b11,1, 4'd4}   // R4 both channels
  };

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic idle_bus();
    ctl_rd = 0; ctl_wr = 0; flg_wr = 0; flg_wdata = '0;
  endtask

  initial begin
    rst = 1; cmp_async = '0; smp_stb = 0; idle_bus();
    ch_en = '0; periph_en = 0; global_en = 0;
    cycles(3);
    // R10: reset state
    chk("R10 reset flag", {2'b0, flag}, 4'b0);
    chk("R10 reset level", {2'b0, ctl_level}, 4'b0);
    chk("R10 reset irq", {3'b0, irq}, 4'b0);
    rst = 0;

    for (int v = 0; v < 15; v++) begin
      cmp_async = VECS[v].cmp; smp_stb = VECS[v].stb;
      ctl_rd = VECS[v].rd; ctl_wr = VECS[v].wr; flg_wr = VECS[v].fwr;
      flg_wdata = VECS[v].fdat; ch_en = VECS[v].chen;
      periph_en = VECS[v].pen; global_en = VECS[v].gen;
      cycles(HOLD);
      chk($sformatf("R%0d vec%0d flag", VECS[v].req, v), {2'b0, flag}, {2'b0, VECS[v].xflag});
      chk($sformatf("R%0d vec%0d level", VECS[v].req, v), {2'b0, ctl_level}, {2'b0, VECS[v].xlvl});
      chk($sformatf("R%0d vec%0d irq", VECS[v].req, v), {3'b0, irq}, {3'b0, VECS[v].xirq});
    end

    // settle: reference 00, flags cleared
    idle_bus(); cmp_async = 2'b00; smp_stb = 1; ctl_rd = 1; cycles(HOLD);
    ctl_rd = 0; flg_wr = 1; cycles(1); idle_bus(); cycles(2);
    chk("R6 settle flag", {2'b0, flag}, 4'b0);

    // R9: synchronized change waits, then read and strobe coincide
    smp_stb = 0; cmp_async = 2'b01; cycles(4);
    ctl_rd = 1; smp_stb = 1; cycles(1);
    ctl_rd = 0; cycles(5);
    chk("R9 no phantom flag", {2'b0, flag}, 4'b0);
    chk("R9 level taken", {2'b0, ctl_level}, 4'b0001);

    // R3: latency of a change to the flag
    cmp_async = 2'b00; cycles(3);
    chk("R3 not before edge 4", {2'b0, flag}, 4'b0);
    cycles(1);
    chk("R3 at edge 4", {2'b0, flag}, 4'b0001);

    // R10: reset in mid-run clears flags and request
    ch_en = 2'b11; periph_en = 1; global_en = 1; cycles(2);
    chk("R8 pre-reset irq", {3'b0, irq}, 4'b0001);
    rst = 1; cycles(1); rst = 0;
    chk("R10 mid reset flag", {2'b0, flag}, 4'b0);
    chk("R10 mid reset irq", {3'b0, irq}, 4'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule